// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block is the configuration front end of a programmable clock synthesizer. It keeps the settings that the downstream dividers use: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit test selector. Two paths can write these settings. The parallel path reads static pins while an active-low parallel strobe is low, and keeps the last sample once the strobe rises. The serial path shifts a 14-bit word in on a slow serial clock. A load strobe then moves the word into the held settings. While that load strobe stays high, the path instead passes each shifted word straight through.

All five control inputs are asynchronous: serial clock, serial data, serial load, parallel strobe and master reset. Each one crosses into the system clock domain through a synchronizer, and edges are detected in that domain. A test output is driven from one of four sources, chosen by the loaded selector. A lock-range flag reports whether the held feedback value is inside the range the loop can lock to.

Top module: `synth_cfg_front`

## Requirements
- R1: After the system reset, the feedback value, output code and test selector are all zero, `test_out` is low and `m_ok` is low.
- R2: While the synchronized `pload_n_a` is low, `m_val` and `n_val` follow `m_pin` and `n_pin`, one system clock after each pin change.
- R3: Once `pload_n_a` has risen, `m_val` and `n_val` keep the last sampled pin values, and later pin changes have no effect.
- R4: In serial mode (`pload_n_a` high), each rising `sclk_a` shifts `sdata_a` into a 14-bit register. The first bit shifted lands in `t_sel[1]`. The order is t_sel[1], t_sel[0], n_val[2:0], m_val[8:0] from the MSB down, and the last bit shifted lands in `m_val[0]`. While `sload_a` is low, shifting does not change the outputs.
- R5: A rising `sload_a` in serial mode copies the shift register into `t_sel`, `n_val` and `m_val`.
- R6: While `sload_a` is high in serial mode, each rising `sclk_a` puts the newly shifted word on `t_sel`, `n_val` and `m_val`.
- R7: After `sload_a` falls, further shifting leaves the outputs unchanged.
- R8: `test_out` follows `t_sel` in serial mode: 00 gives low, 01 gives synchronized `sdata_a`, 10 gives `mdiv_clk`, 11 gives `fout_clk`.
- R9: While the synchronized `pload_n_a` is low, `test_out` is low whatever `t_sel` holds.
- R10: Master reset `mr_a` does not change `m_val`, `n_val` or `t_sel`, but it clears the shift register.
- R11: `m_ok` is high exactly when 250 <= `m_val` <= 500. Values outside this range are still held.
- R12: In parallel mode, serial clock edges and serial load edges do not change the shift register or `t_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sclk_a | input | 1 | Asynchronous serial clock |
| sdata_a | input | 1 | Asynchronous serial data |
| sload_a | input | 1 | Asynchronous serial load strobe |
| pload_n_a | input | 1 | Asynchronous active-low parallel strobe |
| mr_a | input | 1 | Asynchronous master reset for the divider chain |
| m_pin | input | 9 | Parallel feedback divide pins |
| n_pin | input | 3 | Parallel output divide code pins |
| mdiv_clk | input | 1 | Feedback divider output, observed on the test pin |
| fout_clk | input | 1 | Synthesized output clock, observed on the test pin |
| m_val | output | 9 | Held feedback divide value |
| n_val | output | 3 | Held output divide code |
| t_sel | output | 2 | Held test selector |
| test_out | output | 1 | Test pin |
| m_ok | output | 1 | Feedback value is inside the lock range |

## Verification
The hardest state to reach is a shift register whose contents differ from the held settings after parallel-mode activity. Reaching it shows that serial edges in parallel mode and master reset both behave as required. The bench first loads a known word and then drops the parallel strobe. It toggles the serial clock and load with data of the opposite polarity, returns to serial mode and raises the load. The word it sees proves whether the shift register was disturbed. A single pass-through shift after a master reset then shows that the register was cleared, without ever reading it directly.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 3;
  localparam int T_W  = 2;
  localparam int SH_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;

  // lock-range test on the feedback value
  function automatic logic m_in_lock(input logic [M_W-1:0] m, input int lo, input int hi);
    int v;
    v = int'(m);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/cfgf_sync.sv
module cfgf_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_a;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgf_rise.sv
module cfgf_rise #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/cfgf_shifter.sv
module cfgf_shifter
  import cfgf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_en,
  input  logic      clear,
  input  logic      din,
  output cfg_word_t nxt
);
  cfg_word_t q;

  always_comb begin
    nxt = q;
    if (shift_en) nxt = cfg_word_t'({q[SH_W-2:0], din});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else            q <= nxt;
  end
endmodule

// File: rtl/cfgf_hold.sv
module cfgf_hold
  import cfgf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_follow,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_load,
  input  cfg_word_t      ser_word,
  output cfg_word_t      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (par_follow) begin
      q.m <= par_m;
      q.n <= par_n;
    end else if (ser_load) begin
      q <= ser_word;
    end
  end
endmodule

// File: rtl/cfgf_test_mux.sv
module cfgf_test_mux
  import cfgf_pkg::*;
(
  input  logic           par_mode,
  input  logic [T_W-1:0] sel,
  input  logic           sdata,
  input  logic           mdiv,
  input  logic           fout,
  output logic           test_out
);
  always_comb begin
    if (par_mode) test_out = 1'b0;
    else begin
      unique case (sel)
        2'b00:   test_out = 1'b0;
        2'b01:   test_out = sdata;
        2'b10:   test_out = mdiv;
        default: test_out = fout;
      endcase
    end
  end
endmodule

// File: rtl/synth_cfg_front.sv
module synth_cfg_front
  import cfgf_pkg::*;
#(
  parameter int M_MIN = 250,
  parameter int M_MAX = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_a,
  input  logic           sdata_a,
  input  logic           sload_a,
  input  logic           pload_n_a,
  input  logic           mr_a,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           mdiv_clk,
  input  logic           fout_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_sel,
  output logic           test_out,
  output logic           m_ok
);
  localparam int NSYNC = 5;
  // bit order of the synchronized control vector
  localparam int IX_SCLK = 0;
  localparam int IX_SDAT = 1;
  localparam int IX_SLD  = 2;
  localparam int IX_PLD  = 3;
  localparam int IX_MR   = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = NSYNC'(1) << IX_PLD;

  logic [NSYNC-1:0] ctl_lvl;
  logic [1:0]       ctl_rise;

  // named events, also observed by the checker
  logic sclk_lvl, sdata_lvl, sload_lvl, pload_lvl, mr_lvl;
  logic sclk_rise, sload_rise;
  logic ser_mode, shift_ev, ser_load;
  cfg_word_t sh_nxt, held;

  cfgf_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_a({mr_a, pload_n_a, sload_a, sdata_a, sclk_a}),
    .q(ctl_lvl)
  );

  assign sclk_lvl  = ctl_lvl[IX_SCLK];
  assign sdata_lvl = ctl_lvl[IX_SDAT];
  assign sload_lvl = ctl_lvl[IX_SLD];
  assign pload_lvl = ctl_lvl[IX_PLD];
  assign mr_lvl    = ctl_lvl[IX_MR];

  cfgf_rise #(.W(2)) u_rise (
    .clk(clk), .rst_n(rst_n),
    .lvl({sload_lvl, sclk_lvl}),
    .rise(ctl_rise)
  );

  assign sclk_rise  = ctl_rise[0];
  assign sload_rise = ctl_rise[1];

  assign ser_mode = pload_lvl;
  assign shift_ev = ser_mode & sclk_rise;
  // load on the strobe's rise, or on every shift while it stays high
  assign ser_load = ser_mode & sload_lvl & (sclk_rise | sload_rise);

  cfgf_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_ev), .clear(mr_lvl), .din(sdata_lvl),
    .nxt(sh_nxt)
  );

  cfgf_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .par_follow(~pload_lvl), .par_m(m_pin), .par_n(n_pin),
    .ser_load(ser_load), .ser_word(sh_nxt),
    .q(held)
  );

  cfgf_test_mux u_tmux (
    .par_mode(~pload_lvl), .sel(held.t), .sdata(sdata_lvl),
    .mdiv(mdiv_clk), .fout(fout_clk), .test_out(test_out)
  );

  assign m_val = held.m;
  assign n_val = held.n;
  assign t_sel = held.t;
  assign m_ok  = m_in_lock(held.m, M_MIN, M_MAX);
endmodule

// File: rtl/synth_cfg_front_chk.sv
module synth_cfg_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pload_lvl,
  input logic       sload_lvl,
  input logic       sclk_rise,
  input logic       sdata_lvl,
  input logic [8:0] m_pin,
  input logic [2:0] n_pin,
  input logic [8:0] m_val,
  input logic [2:0] n_val,
  input logic [1:0] t_sel,
  input logic       test_out
);
  // R9
  par_test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_lvl |-> !test_out);

  // R2
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_lvl |=> (m_val == $past(m_pin)) && (n_val == $past(n_pin)));

  // R12
  par_t_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_lvl |=> $stable(t_sel));

  // R4
  ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_lvl && !sload_lvl) |=> $stable({t_sel, n_val, m_val}));

  // R6
  pass_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_lvl && sload_lvl && sclk_rise) |=> (m_val[0] == $past(sdata_lvl)));
endmodule

bind synth_cfg_front synth_cfg_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pload_lvl(pload_lvl), .sload_lvl(sload_lvl),
  .sclk_rise(sclk_rise), .sdata_lvl(sdata_lvl), .m_pin(m_pin), .n_pin(n_pin),
  .m_val(m_val), .n_val(n_val), .t_sel(t_sel), .test_out(test_out)
);

// File: tb/sim_synth_cfg_front.sv
module sim_synth_cfg_front;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_a = 0, sdata_a = 0, sload_a = 0, pload_n_a = 1, mr_a = 0;
  logic [8:0] m_pin = '0;
  logic [2:0] n_pin = '0;
  logic mdiv_clk = 0, fout_clk = 0;
  logic [8:0] m_val;
  logic [2:0] n_val;
  logic [1:0] t_sel;
  logic test_out, m_ok;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  synth_cfg_front u0 (
    .clk(clk), .rst_n(rst_n), .sclk_a(sclk_a), .sdata_a(sdata_a),
    .sload_a(sload_a), .pload_n_a(pload_n_a), .mr_a(mr_a),
    .m_pin(m_pin), .n_pin(n_pin), .mdiv_clk(mdiv_clk), .fout_clk(fout_clk),
    .m_val(m_val), .n_val(n_val), .t_sel(t_sel), .test_out(test_out), .m_ok(m_ok)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int word_of(input logic [1:0] t, input logic [2:0] n, input logic [8:0] m);
    return int'({t, n, m});
  endfunction

  task automatic sclk_pulse(input logic d);
    sdata_a = d; tick(4);
    sclk_a = 1;  tick(4);
    sclk_a = 0;  tick(4);
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) sclk_pulse(w[i]);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [13:0] w, exp_w;
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 reset state
    chk("R1 word", word_of(t_sel, n_val, m_val), 0);
    chk("R1 test", int'(test_out), 0);
    chk("R1 m_ok", int'(m_ok), 0);

    // R2 / R11 parallel sweep over every feedback value
    pload_n_a = 0; tick(5);
    for (int m = 0; m < 512; m++) begin
      m_pin = 9'(m);
      n_pin = 3'(m) ^ 3'd5;
      tick(2);
      chk("R2 m", int'(m_val), m);
      chk("R2 n", int'(n_val), int'(3'(m) ^ 3'd5));
      chk("R11 m_ok", int'(m_ok), (m >= 250 && m <= 500) ? 1 : 0);
    end

    // R3 capture on strobe rise
    m_pin = 9'd300; n_pin = 3'd2; tick(2);
    pload_n_a = 1; tick(5);
    m_pin = 9'd7; n_pin = 3'd6; tick(5);
    chk("R3 m", int'(m_val), 300);
    chk("R3 n", int'(n_val), 2);

    // R4 shift without load keeps outputs
    w = {2'b01, 3'd3, 9'd420};
    shift_word(w);
    chk("R4 quiet", word_of(t_sel, n_val, m_val), word_of(2'b00, 3'd2, 9'd300));

    // R5 load on rise
    sload_a = 1; tick(6);
    chk("R5 load", word_of(t_sel, n_val, m_val), int'(w));

    // R8 selector 01 -> serial data
    sdata_a = 1; tick(4);
    chk("R8 sel01 hi", int'(test_out), 1);
    sdata_a = 0; tick(4);
    chk("R8 sel01 lo", int'(test_out), 0);

    // R7 freeze after fall
    sload_a = 0; tick(6);
    w = {2'b10, 3'd5, 9'd77};
    shift_word(w);
    chk("R7 frozen", word_of(t_sel, n_val, m_val), word_of(2'b01, 3'd3, 9'd420));

    sload_a = 1; tick(6);
    chk("R5 load2", word_of(t_sel, n_val, m_val), int'(w));
    chk("R11 low", int'(m_ok), 0);
    mdiv_clk = 1; tick(1);
    chk("R8 sel10 hi", int'(test_out), 1);
    mdiv_clk = 0; tick(1);
    chk("R8 sel10 lo", int'(test_out), 0);

    // R6 pass-through, one check per shifted bit
    exp_w = w;
    w = {2'b11, 3'd1, 9'd250};
    for (int i = 13; i >= 0; i--) begin
      sclk_pulse(w[i]);
      exp_w = {exp_w[12:0], w[i]};
      chk("R6 pass", word_of(t_sel, n_val, m_val), int'(exp_w));
    end
    chk("R11 edge", int'(m_ok), 1);
    fout_clk = 1; tick(1);
    chk("R8 sel11 hi", int'(test_out), 1);
    fout_clk = 0; tick(1);
    chk("R8 sel11 lo", int'(test_out), 0);
    sload_a = 0; tick(6);
    chk("R8 sel00 path", int'(t_sel), 3);

    // R9 parallel mode forces test low
    fout_clk = 1; m_pin = 9'd250; n_pin = 3'd1;
    pload_n_a = 0; tick(5);
    chk("R9 test low", int'(test_out), 0);

    // R12 serial activity in parallel mode is ignored
    for (int i = 0; i < 6; i++) sclk_pulse(~w[i]);
    sload_a = 1; tick(6); sload_a = 0; tick(6);
    chk("R12 t kept", int'(t_sel), 3);
    pload_n_a = 1; tick(6);
    sload_a = 1; tick(6);
    chk("R12 shreg kept", word_of(t_sel, n_val, m_val), int'(w));
    fout_clk = 0;

    // R10 master reset keeps settings, clears shift register
    mr_a = 1; tick(6);
    mr_a = 0; tick(4);
    chk("R10 keep", word_of(t_sel, n_val, m_val), int'(w));
    sclk_pulse(1'b1);
    chk("R10 cleared", word_of(t_sel, n_val, m_val), 1);
    sload_a = 0; tick(4);

    finish_run();
  end
endmodule